// File: doc/BRIEF.md
# Edge-Triggered Interrupt Source Merger

This block watches three digital signals: two amplifier outputs and one comparator output. It turns the qualifying edges on them into sticky per-source request flags. It also raises one merged interrupt request toward a central interrupt controller. An amplifier source qualifies on a high-to-low edge. The comparator qualifies on a change in either direction.

Software sees one 8-bit control/status word. The word holds a sticky flag and an enable for each source. The merged request is cleared by an acknowledge pulse from the interrupt controller when the request is serviced. The per-source flags are left untouched by that acknowledge, so the service routine can read them to learn which source fired. A flag is cleared only when software writes 0 to it.

The read port is a continuous view of the word. A write takes effect at the next clock edge. There is no streaming data path, so every pin is a plain level or pulse.

Top module: `irq_source_merge`

## Requirements
- R1: A high-to-low change on `amp0_i` sets the status bit at position 5, and one on `amp1_i` sets the bit at position 6. The bit is visible on `csr_rdata` one clock after the edge is sampled. A low-to-high change on either amplifier input sets nothing.
- R2: Any change of `cmp_i`, rising or falling, sets the status bit at position 4 one clock after the change is sampled.
- R3: The layout of `csr_rdata` is fixed, with each bit meaning the following:
  - bit 6: amp1 flag
  - bit 5: amp0 flag
  - bit 4: comparator flag
  - bit 2: amp1 enable
  - bit 1: amp0 enable
  - bit 0: comparator enable
  - bits 7 and 3: always read 0
- R4: After reset, `csr_rdata` is 0x00 and `irq_req` is low.
- R5: A write with `csr_we` high clears each flag whose bit in `csr_wdata` is 0. A 1 in a flag position leaves that flag unchanged.
- R6: Each write loads the enable bits (positions 2, 1, 0) from `csr_wdata`. The new value is readable one clock later.
- R7: A qualifying edge raises `irq_req` one clock later only if that source's enable bit is 1 in the cycle of the edge. Edges on disabled sources still set their flags.
- R8: `irq_ack` drops `irq_req` at the next clock. The per-source flags are unaffected by the acknowledge.
- R9: The first clock after reset release detects no edge, whatever level the inputs held through reset.
- R10: An edge and a write clearing the same flag in the same cycle leave the flag set.
- R11: An enabled qualifying edge in the same cycle as `irq_ack` leaves `irq_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| amp0_i | input | 1 | First amplifier output, falling edge qualifies |
| amp1_i | input | 1 | Second amplifier output, falling edge qualifies |
| cmp_i | input | 1 | Comparator output, any change qualifies |
| csr_we | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Current control/status word |
| irq_ack | input | 1 | Service acknowledge, clears the merged request |
| irq_req | output | 1 | Merged interrupt request |

## Verification
Every result of this block is due exactly one clock after its stimulus is sampled. This covers a flag set by an edge, a flag cleared or an enable loaded by a write, and `irq_req` set or dropped. The single exception is the first clock after reset, which yields nothing. The bench therefore changes inputs on the falling clock edge and compares both outputs at the following falling edge. The expected values come from a bench-side model of the requirements that is advanced once per step. Sweeps cover every source, both edge directions, both enable settings and all 256 write values. Directed steps cover the same-cycle collisions.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int NSRC     = 3;
  localparam int CSR_W    = 8;
  localparam int EN_LSB   = 0;
  localparam int FLAG_LSB = 4;
  localparam int SRC_CMP  = 0;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_ANY  = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/irqm_edge.sv
module irqm_edge
  import irqm_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_ANY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic evt_o
);
  logic prev_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= sig_i;
      armed_q <= 1'b1;
    end
  end

  generate
    if (KIND == EDGE_FALL) begin : g_fall
      assign evt_o = armed_q & prev_q & ~sig_i;

      property p_fall_only;
        @(posedge clk) disable iff (!rst_n)
          evt_o |-> ($past(sig_i) && !sig_i);
      endproperty
      assert_fall_only_R1: assert property (p_fall_only);
    end else begin : g_any
      assign evt_o = armed_q & (prev_q ^ sig_i);

      property p_change_only;
        @(posedge clk) disable iff (!rst_n)
          evt_o |-> (sig_i != $past(sig_i));
      endproperty
      assert_change_only_R2: assert property (p_change_only);
    end
  endgenerate
endmodule

// File: rtl/irqm_regs.sv
module irqm_regs
  import irqm_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     evt,
  input  logic             we,
  input  logic [CSR_W-1:0] wdata,
  output logic [N-1:0]     en_q,
  output logic [CSR_W-1:0] rdata
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic clr;
    assign clr = we & ~wdata[FLAG_LSB+i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        flag_q[i] <= (flag_q[i] & ~clr) | evt[i];
        if (we) en_q[i] <= wdata[EN_LSB+i];
      end
    end

    property p_evt_sets;
      @(posedge clk) disable iff (!rst_n) evt[i] |=> flag_q[i];
    endproperty
    assert_evt_wins_R10: assert property (p_evt_sets);

    property p_one_keeps;
      @(posedge clk) disable iff (!rst_n)
        (we && wdata[FLAG_LSB+i] && !evt[i]) |=> (flag_q[i] == $past(flag_q[i]));
    endproperty
    assert_one_keeps_R5: assert property (p_one_keeps);

    property p_zero_clears;
      @(posedge clk) disable iff (!rst_n)
        (we && !wdata[FLAG_LSB+i] && !evt[i]) |=> !flag_q[i];
    endproperty
    assert_zero_clears_R5: assert property (p_zero_clears);

    property p_en_load;
      @(posedge clk) disable iff (!rst_n)
        we |=> (en_q[i] == $past(wdata[EN_LSB+i]));
    endproperty
    assert_en_load_R6: assert property (p_en_load);
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N; k++) begin
      rdata[FLAG_LSB+k] = flag_q[k];
      rdata[EN_LSB+k]   = en_q[k];
    end
  end
endmodule

// File: rtl/irqm_merge.sv
module irqm_merge
  import irqm_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic         ack,
  output logic         req_q
);
  logic hit;
  assign hit = |(evt & en);

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= hit | (req_q & ~ack);
  end

  property p_hit_sets;
    @(posedge clk) disable iff (!rst_n) hit |=> req_q;
  endproperty
  assert_hit_beats_ack_R11: assert property (p_hit_sets);

  property p_ack_drops;
    @(posedge clk) disable iff (!rst_n) (ack && !hit) |=> !req_q;
  endproperty
  assert_ack_drops_R8: assert property (p_ack_drops);

  property p_no_spurious;
    @(posedge clk) disable iff (!rst_n) (!req_q && !hit) |=> !req_q;
  endproperty
  assert_no_spurious_R7: assert property (p_no_spurious);
endmodule

// File: rtl/irq_source_merge.sv
module irq_source_merge
  import irqm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             amp0_i,
  input  logic             amp1_i,
  input  logic             cmp_i,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  input  logic             irq_ack,
  output logic             irq_req
);
  logic [NSRC-1:0] src;
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] en;

  assign src = {amp1_i, amp0_i, cmp_i};

  for (genvar i = 0; i < NSRC; i++) begin : g_det
    localparam edge_kind_e KIND = (i == SRC_CMP) ? EDGE_ANY : EDGE_FALL;
    irqm_edge #(.KIND(KIND)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_i (src[i]),
      .evt_o (evt[i])
    );
  end

  irqm_regs #(.N(NSRC)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .we    (csr_we),
    .wdata (csr_wdata),
    .en_q  (en),
    .rdata (csr_rdata)
  );

  irqm_merge #(.N(NSRC)) u_merge (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .en    (en),
    .ack   (irq_ack),
    .req_q (irq_req)
  );

  property p_flags_persist;
    @(posedge clk) disable iff (!rst_n)
      (irq_ack && !csr_we) |=>
        ((csr_rdata[6:4] & $past(csr_rdata[6:4])) == $past(csr_rdata[6:4]));
  endproperty
  assert_flags_persist_R8: assert property (p_flags_persist);
endmodule

// File: tb/irq_source_merge_tb.sv
`timescale 1ns/1ps
module irq_source_merge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       amp0_i, amp1_i, cmp_i;
  logic       csr_we = 1'b0;
  logic [7:0] csr_wdata = 8'h00;
  logic [7:0] csr_rdata;
  logic       irq_ack = 1'b0;
  logic       irq_req;

  int checks = 0;
  int errors = 0;

  logic [2:0] m_prev = 3'b000;
  logic       m_armed = 1'b0;
  logic [2:0] m_flag = 3'b000;
  logic [2:0] m_en = 3'b000;
  logic       m_req = 1'b0;
  logic [2:0] cur = 3'b111;

  always #4 clk = ~clk;

  irq_source_merge u_dut (
    .clk(clk), .rst_n(rst_n), .amp0_i(amp0_i), .amp1_i(amp1_i), .cmp_i(cmp_i),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // src bit 0 = comparator, bit 1 = amp0, bit 2 = amp1
  task automatic drive(input logic [2:0] s, input logic we, input logic [7:0] wd,
                       input logic ack, input string tag);
    logic [2:0] ev;
    logic [2:0] en_old;
    {amp1_i, amp0_i, cmp_i} = s;
    csr_we = we; csr_wdata = wd; irq_ack = ack;
    ev[0] = m_armed & (m_prev[0] ^ s[0]);
    ev[1] = m_armed & m_prev[1] & ~s[1];
    ev[2] = m_armed & m_prev[2] & ~s[2];
    en_old = m_en;
    m_flag = (m_flag & ~(we ? ~wd[6:4] : 3'b000)) | ev;
    if (we) m_en = wd[2:0];
    m_req = (|(ev & en_old)) | (m_req & ~ack);
    m_prev = s; m_armed = 1'b1; cur = s;
    @(posedge clk); @(negedge clk);
    csr_we = 1'b0; irq_ack = 1'b0;
    check({tag, " rdata"}, csr_rdata, {1'b0, m_flag, 1'b0, m_en});
    check({tag, " irq_req"}, {7'd0, irq_req}, {7'd0, m_req});
  endtask

  task automatic set_all_flags();
    drive(3'b111, 1'b0, 8'h00, 1'b0, "R1 prep");
    drive(3'b000, 1'b0, 8'h00, 1'b0, "R1 R2 set");
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    {amp1_i, amp0_i, cmp_i} = 3'b111;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R4 reset rdata", csr_rdata, 8'h00);
    check("R4 reset irq_req", {7'd0, irq_req}, 8'h00);
    // R9: inputs held high through reset, comparator 1 vs cleared history
    drive(3'b111, 1'b0, 8'h00, 1'b0, "R9 first cycle");
    drive(3'b111, 1'b0, 8'h00, 1'b0, "R9 quiet");

    // R1 R2 R7 sweep: each source, each direction, each enable
    for (int s = 0; s < 3; s++)
      for (int e = 0; e < 2; e++)
        for (int d = 0; d < 2; d++) begin
          logic [2:0] lvl;
          logic [7:0] wd;
          wd = {5'b0, 3'(e << s)};
          lvl = cur;
          lvl[s] = d[0];
          drive(lvl, 1'b1, wd, 1'b1, "R6 R8 setup");
          drive(lvl, 1'b1, wd, 1'b1, "R5 setup");
          lvl[s] = ~d[0];
          drive(lvl, 1'b0, 8'h00, 1'b0, (s == 0) ? "R2 R7 edge" : "R1 R7 edge");
          drive(lvl, 1'b0, 8'h00, 1'b0, "R1 R2 hold");
        end

    // R3 R5 R6 R8: every write value over all-set flags, then acknowledge
    for (int w = 0; w < 256; w++) begin
      set_all_flags();
      drive(cur, 1'b1, 8'(w), 1'b0, "R3 R5 R6 write");
      drive(cur, 1'b0, 8'h00, 1'b1, "R8 ack keeps flags");
    end

    // R10: comparator edge with clearing write in the same cycle
    drive(cur, 1'b1, 8'h07, 1'b1, "R10 setup");
    drive(cur ^ 3'b001, 1'b1, 8'h07, 1'b0, "R10 edge beats clear");
    // R11: enabled amp1 fall together with acknowledge
    drive(cur | 3'b100, 1'b0, 8'h00, 1'b0, "R11 setup");
    drive(cur, 1'b0, 8'h00, 1'b1, "R11 clean ack");
    drive(cur & 3'b011, 1'b0, 8'h00, 1'b1, "R11 edge beats ack");
    drive(cur, 1'b0, 8'h00, 1'b1, "R8 ack drops");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule